// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the bit-rate clocks and frame syncs for the transmit and receive halves of a multichannel audio serial port. Each direction has two cascaded programmable dividers. A high-frequency divider runs off the functional clock, and a bit-rate divider follows it. A two-bit mode per direction picks what feeds the bit clock. In internal mode both dividers are used. In external-bit mode a strobe arriving on the bit clock pin is used directly. In external-high-frequency mode a strobe on the high-frequency pin goes through the bit-rate divider only.

The receive direction has one more mode code, which makes it synchronous. In that mode the receive bit clock and the receive frame sync both follow the transmit side, and the receive dividers stay idle. The block also drives the pin direction enables, an optional high-frequency reference output, and the selected frame syncs.

Everything runs in the functional clock domain. Every clock is a one-cycle enable pulse ("tick"). External clock inputs are ticks that have already been synchronized to this domain. A divide field holding N divides by N+1, so N=0 passes the input through unchanged.

Top module: `audio_clkgen`

## Requirements
- R1: In internal mode (mode code 0), with high-frequency field H and bit field B, the bit clock ticks once every (H+1)*(B+1) functional clock cycles, and the bit clock pin enable is high.
- R2: In external-bit mode (mode code 1), the bit clock equals the bit clock input strobe in the same cycle. Both divide fields have no effect, and the bit clock and high-frequency pin enables are low.
- R3: In external-high-frequency mode (mode code 2), the bit clock ticks on every (B+1)-th high-frequency input strobe. The high-frequency field has no effect, the bit clock pin enable is high, and the high-frequency pin enable and reference output stay low.
- R4: In internal mode with the reference enable high, the high-frequency reference output ticks every H+1 cycles and its pin enable is high. With the reference enable low, both stay low.
- R5: Receive mode code 3 (synchronous) makes the receive bit clock equal the transmit bit clock and the receive frame sync equal the transmit frame sync. The receive pin enables stay low, and the receive strobe inputs and external frame sync are ignored.
- R6: Each direction's frame sync output is its external frame sync input when that direction's select bit is 1, and its internal one when the bit is 0. The two directions select independently.
- R7: Transmit mode code 3 behaves exactly as internal mode.
- R8: A change of the mode or either divide field clears the divider counters and suppresses output ticks in the cycle of the change. The first tick then comes a full new period later: at the (H+1)*(B+1)-th cycle after the change edge for the bit clock, and at the (H+1)-th for the reference output.
- R9: While reset is asserted, all bit clock and reference outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 2 | Transmit clock source mode |
| rx_mode | input | 2 | Receive clock source mode (3 = synchronous) |
| tx_hdiv | input | HDW | Transmit high-frequency divide field |
| tx_bdiv | input | BDW | Transmit bit-rate divide field |
| rx_hdiv | input | HDW | Receive high-frequency divide field |
| rx_bdiv | input | BDW | Receive bit-rate divide field |
| tx_hf_out_en | input | 1 | Drive transmit high-frequency reference out |
| rx_hf_out_en | input | 1 | Drive receive high-frequency reference out |
| tx_bclk_in | input | 1 | External transmit bit clock strobe |
| rx_bclk_in | input | 1 | External receive bit clock strobe |
| tx_hf_in | input | 1 | External transmit high-frequency strobe |
| rx_hf_in | input | 1 | External receive high-frequency strobe |
| tx_fs_sel | input | 1 | Transmit frame sync select (1 = external) |
| rx_fs_sel | input | 1 | Receive frame sync select (1 = external) |
| tx_fs_int | input | 1 | Internally generated transmit frame sync |
| tx_fs_ext | input | 1 | External transmit frame sync |
| rx_fs_int | input | 1 | Internally generated receive frame sync |
| rx_fs_ext | input | 1 | External receive frame sync |
| tx_bclk | output | 1 | Transmit bit clock tick |
| rx_bclk | output | 1 | Receive bit clock tick |
| tx_hf_out | output | 1 | Transmit high-frequency reference tick |
| rx_hf_out | output | 1 | Receive high-frequency reference tick |
| tx_bclk_oe | output | 1 | Transmit bit clock pin drive enable |
| rx_bclk_oe | output | 1 | Receive bit clock pin drive enable |
| tx_hf_oe | output | 1 | Transmit high-frequency pin drive enable |
| rx_hf_oe | output | 1 | Receive high-frequency pin drive enable |
| tx_fs | output | 1 | Selected transmit frame sync |
| rx_fs | output | 1 | Selected receive frame sync |

## Verification
The internal path is swept over every pair of small divide fields in both directions, plus the largest pair. This separates a wrong stage ordering, an off-by-one in either counter, and a missing restart after a change, because each run times the first tick from the change edge as well as the steady spacing. The external strobe modes are driven with periodic strobes while the divide fields are rewritten. A bypassed stage therefore shows up as a changed period or a broken pass-through. Synchronous mode is run with conflicting receive strobes and frame syncs, so any leak from the receive pins is visible. All frame sync select and level combinations are tried in both directions.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int HDW = 6,
  parameter int BDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     tx_mode,
  input  logic [1:0]     rx_mode,
  input  logic [HDW-1:0] tx_hdiv,
  input  logic [BDW-1:0] tx_bdiv,
  input  logic [HDW-1:0] rx_hdiv,
  input  logic [BDW-1:0] rx_bdiv,
  input  logic           tx_hf_out_en,
  input  logic           rx_hf_out_en,
  input  logic           tx_bclk_in,
  input  logic           rx_bclk_in,
  input  logic           tx_hf_in,
  input  logic           rx_hf_in,
  input  logic           tx_fs_sel,
  input  logic           rx_fs_sel,
  input  logic           tx_fs_int,
  input  logic           tx_fs_ext,
  input  logic           rx_fs_int,
  input  logic           rx_fs_ext,
  output logic           tx_bclk,
  output logic           rx_bclk,
  output logic           tx_hf_out,
  output logic           rx_hf_out,
  output logic           tx_bclk_oe,
  output logic           rx_bclk_oe,
  output logic           tx_hf_oe,
  output logic           rx_hf_oe,
  output logic           tx_fs,
  output logic           rx_fs
);
  localparam logic [1:0] M_INT = 2'd0, M_XBIT = 2'd1, M_XHF = 2'd2, M_SYNC = 2'd3;
  localparam int CW = 2 + HDW + BDW;

  logic [1:0]     md  [2];
  logic [HDW-1:0] hdv [2];
  logic [BDW-1:0] bdv [2];
  logic [1:0] b_in, h_in, h_en, gen_b, gen_h, is_int, is_xb, is_xh;
  logic rx_sync;

  assign md[0]  = tx_mode;  assign md[1]  = rx_mode;
  assign hdv[0] = tx_hdiv;  assign hdv[1] = rx_hdiv;
  assign bdv[0] = tx_bdiv;  assign bdv[1] = rx_bdiv;
  assign b_in = {rx_bclk_in, tx_bclk_in};
  assign h_in = {rx_hf_in, tx_hf_in};
  assign h_en = {rx_hf_out_en, tx_hf_out_en};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [CW-1:0]  cfg_q;
    logic [HDW-1:0] hcnt;
    logic [BDW-1:0] bcnt;
    logic chg, htk, bsrc, btk;

    assign is_int[d] = (md[d] == M_INT) || ((d == 0) && (md[d] == M_SYNC));
    assign is_xb[d]  = (md[d] == M_XBIT);
    assign is_xh[d]  = (md[d] == M_XHF);

    assign chg  = ({md[d], hdv[d], bdv[d]} != cfg_q);
    assign htk  = is_int[d] && !chg && (hcnt == hdv[d]);
    assign bsrc = is_int[d] ? htk : (is_xh[d] && h_in[d] && !chg);
    assign btk  = bsrc && (bcnt == bdv[d]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
        hcnt  <= '0;
        bcnt  <= '0;
      end else begin
        cfg_q <= {md[d], hdv[d], bdv[d]};
        if (chg || !is_int[d] || htk) hcnt <= '0;
        else                           hcnt <= hcnt + 1'b1;
        if (chg || !(is_int[d] || is_xh[d])) bcnt <= '0;
        else if (bsrc)                       bcnt <= btk ? '0 : bcnt + 1'b1;
      end
    end

    assign gen_b[d] = rst_n && (is_xb[d] ? b_in[d] : btk);
    assign gen_h[d] = rst_n && htk && h_en[d];
  end

  assign rx_sync    = (rx_mode == M_SYNC);
  assign tx_bclk    = gen_b[0];
  assign rx_bclk    = rx_sync ? gen_b[0] : gen_b[1];
  assign tx_hf_out  = gen_h[0];
  assign rx_hf_out  = gen_h[1];
  assign tx_bclk_oe = is_int[0] || is_xh[0];
  assign rx_bclk_oe = is_int[1] || is_xh[1];
  assign tx_hf_oe   = is_int[0] && tx_hf_out_en;
  assign rx_hf_oe   = is_int[1] && rx_hf_out_en;
  assign tx_fs      = tx_fs_sel ? tx_fs_ext : tx_fs_int;
  assign rx_fs      = rx_sync ? tx_fs : (rx_fs_sel ? rx_fs_ext : rx_fs_int);
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int HDW = 6,
  parameter int BDW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     tx_mode,
  input logic [1:0]     rx_mode,
  input logic [HDW-1:0] tx_hdiv,
  input logic [BDW-1:0] tx_bdiv,
  input logic           tx_bclk_in,
  input logic           tx_bclk,
  input logic           rx_bclk,
  input logic           tx_fs,
  input logic           rx_fs,
  input logic           tx_hf_out,
  input logic           tx_hf_oe,
  input logic           rx_bclk_oe,
  input logic           rx_hf_oe
);
  AST_SYNC_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode == 2'd3 |-> (rx_bclk == tx_bclk) && !rx_bclk_oe && !rx_hf_oe); // R5
  AST_SYNC_FS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode == 2'd3 |-> rx_fs == tx_fs); // R5
  AST_XBIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode == 2'd1 |-> tx_bclk == tx_bclk_in); // R2
  AST_HF_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hf_out |-> tx_hf_oe); // R4
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && tx_mode != 2'd1 && (!$stable(tx_bdiv) || !$stable(tx_hdiv))) |-> !tx_bclk); // R8
  AST_INT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == 2'd0 && tx_bdiv != '0 && tx_bclk) |=> (!tx_bclk || tx_mode != 2'd0)); // R1
endmodule

bind audio_clkgen audio_clkgen_chk #(.HDW(HDW), .BDW(BDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_mode(rx_mode),
  .tx_hdiv(tx_hdiv), .tx_bdiv(tx_bdiv), .tx_bclk_in(tx_bclk_in),
  .tx_bclk(tx_bclk), .rx_bclk(rx_bclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
  .tx_hf_out(tx_hf_out), .tx_hf_oe(tx_hf_oe), .rx_bclk_oe(rx_bclk_oe),
  .rx_hf_oe(rx_hf_oe)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  localparam int HDW = 6, BDW = 5;
  logic clk = 0, rst_n = 0;
  logic [1:0] tx_mode = 0, rx_mode = 0;
  logic [HDW-1:0] tx_hdiv = 0, rx_hdiv = 0;
  logic [BDW-1:0] tx_bdiv = 0, rx_bdiv = 0;
  logic tx_hf_out_en = 0, rx_hf_out_en = 0;
  logic tx_bclk_in = 0, rx_bclk_in = 0, tx_hf_in = 0, rx_hf_in = 0;
  logic tx_fs_sel = 0, rx_fs_sel = 0, tx_fs_int = 0, tx_fs_ext = 0, rx_fs_int = 0, rx_fs_ext = 0;
  logic tx_bclk, rx_bclk, tx_hf_out, rx_hf_out, tx_bclk_oe, rx_bclk_oe, tx_hf_oe, rx_hf_oe, tx_fs, rx_fs;

  int nchk = 0, nfail = 0;
  int per_txb = 0, per_rxb = 0, per_txh = 0, per_rxh = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_clkgen #(.HDW(HDW), .BDW(BDW)) uut (.*);

  // strobe generator: each strobe input pulses every per_* cycles (0 = off)
  initial begin
    int c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    forever begin
      @(posedge clk); #1;
      tx_bclk_in = (per_txb != 0) && (c0 == 0); c0 = (per_txb != 0) ? (c0 + 1) % per_txb : 0;
      rx_bclk_in = (per_rxb != 0) && (c1 == 0); c1 = (per_rxb != 0) ? (c1 + 1) % per_rxb : 0;
      tx_hf_in   = (per_txh != 0) && (c2 == 0); c2 = (per_txh != 0) ? (c2 + 1) % per_txh : 0;
      rx_hf_in   = (per_rxh != 0) && (c3 == 0); c3 = (per_rxh != 0) ? (c3 + 1) % per_rxh : 0;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pick(int sel);
    case (sel)
      0: return tx_bclk;
      1: return rx_bclk;
      2: return tx_hf_out;
      default: return rx_hf_out;
    endcase
  endfunction

  // Called at posedge+2 right after a configuration write.
  task automatic period_run(int sel, int p, bit exact, string req);
    int k = 0, first = -1, last = -1, n = 0, badv = 0, bad = 0;
    #1;
    if (exact) chk(pick(sel) == 0, "R8 change cycle", pick(sel), 0);
    while (n < 4 && k < 6 * p + 200) begin
      @(posedge clk); #3; k++;
      if (pick(sel)) begin
        if (first < 0) first = k;
        else if (k - last != p) begin bad++; badv = k - last; end
        last = k; n++;
      end
    end
    if (exact) chk(first == p, "R8 first tick", first, p);
    chk(n == 4 && bad == 0, req, (bad != 0) ? badv : n, (bad != 0) ? p : 4);
  endtask

  task automatic park(int dir);
    @(posedge clk); #2;
    if (dir == 0) tx_mode = 2'd1; else rx_mode = 2'd1;
    @(posedge clk); #2;
  endtask

  task automatic run_int(int dir, int h, int b, logic [1:0] m, string req);
    park(dir);
    if (dir == 0) begin tx_mode = m; tx_hdiv = HDW'(h); tx_bdiv = BDW'(b); end
    else          begin rx_mode = m; rx_hdiv = HDW'(h); rx_bdiv = BDW'(b); end
    period_run(dir, (h + 1) * (b + 1), 1'b1, req);
    if (dir == 0) chk(tx_bclk_oe == 1, "R1 tx pin enable", tx_bclk_oe, 1);
    else          chk(rx_bclk_oe == 1, "R1 rx pin enable", rx_bclk_oe, 1);
  endtask

  initial begin
    int cnt, mis;
    // R9: internal mode with ratio 1 while in reset: outputs must stay low
    tx_hf_out_en = 1; rx_hf_out_en = 1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #3;
      cnt += tx_bclk + rx_bclk + tx_hf_out + rx_hf_out;
    end
    chk(cnt == 0, "R9 reset outputs low", cnt, 0);
    @(negedge clk); rst_n = 1;
    tx_hf_out_en = 0; rx_hf_out_en = 0;

    // R1/R8: internal sweep, both directions
    for (int h = 0; h < 4; h++)
      for (int b = 0; b < 4; b++) begin
        run_int(0, h, b, 2'd0, "R1 tx internal period");
        run_int(1, h, b, 2'd0, "R1 rx internal period");
      end
    run_int(0, 63, 31, 2'd0, "R1 tx largest ratio");
    // R7: tx mode 3 acts as internal
    run_int(0, 2, 3, 2'd3, "R7 tx mode 3 period");

    // R4: reference output
    tx_hf_out_en = 1; rx_hf_out_en = 1;
    park(0); tx_mode = 0; tx_hdiv = 4; tx_bdiv = 1;
    period_run(2, 5, 1'b1, "R4 tx reference period");
    chk(tx_hf_oe == 1, "R4 tx reference pin enable", tx_hf_oe, 1);
    park(1); rx_mode = 0; rx_hdiv = 2; rx_bdiv = 6;
    period_run(3, 3, 1'b1, "R4 rx reference period");
    tx_hf_out_en = 0; rx_hf_out_en = 0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #3; cnt += tx_hf_out + rx_hf_out + tx_hf_oe + rx_hf_oe; end
    chk(cnt == 0, "R4 reference disabled", cnt, 0);

    // R2: external bit clock, divide fields rewritten every cycle
    tx_hf_out_en = 1;
    @(posedge clk); #2; tx_mode = 1; per_txb = 3;
    mis = 0; cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2; tx_hdiv = HDW'(i); tx_bdiv = BDW'(i * 3);
      #1; if (tx_bclk != tx_bclk_in) mis++; cnt += tx_bclk;
      if (tx_bclk_oe || tx_hf_oe || tx_hf_out) mis++;
    end
    chk(mis == 0 && cnt == 20, "R2 external bit pass-through", (mis != 0) ? mis : cnt, (mis != 0) ? 0 : 20);
    per_txb = 0;

    // R3: external high-frequency strobe, hdiv must not matter
    per_txh = 3;
    @(posedge clk); #2; tx_mode = 2; tx_hdiv = 0; tx_bdiv = 2;
    period_run(0, 9, 1'b0, "R3 ext hf period hdiv=0");
    @(posedge clk); #2; tx_hdiv = 40;
    period_run(0, 9, 1'b0, "R3 ext hf period hdiv=40");
    chk(tx_bclk_oe == 1 && tx_hf_oe == 0, "R3 pin enables", {tx_bclk_oe, tx_hf_oe}, 2);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #3; cnt += tx_hf_out; end
    chk(cnt == 0, "R3 no reference out", cnt, 0);
    per_rxh = 2;
    park(1); rx_mode = 2; rx_hdiv = 9; rx_bdiv = 4;
    period_run(1, 10, 1'b0, "R3 rx ext hf period");
    per_txh = 0; per_rxh = 0; tx_hf_out_en = 0;

    // R5: synchronous receive with conflicting receive inputs
    @(posedge clk); #2;
    tx_mode = 0; tx_hdiv = 1; tx_bdiv = 2; rx_mode = 3; rx_hdiv = 0; rx_bdiv = 0;
    rx_hf_out_en = 1; per_rxb = 2; per_rxh = 1; rx_fs_sel = 1;
    mis = 0; cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2; tx_fs_int = i[2]; rx_fs_ext = ~i[2]; rx_fs_int = i[0];
      #1; if (rx_bclk != tx_bclk || rx_fs != tx_fs) mis++;
      if (rx_bclk_oe || rx_hf_oe || rx_hf_out) mis++;
      cnt += rx_bclk;
    end
    chk(mis == 0 && cnt == 10, "R5 sync follows transmit", (mis != 0) ? mis : cnt, (mis != 0) ? 0 : 10);
    per_rxb = 0; per_rxh = 0; rx_hf_out_en = 0;

    // R6: frame sync selection, all combinations, asynchronous
    @(posedge clk); #2; rx_mode = 0;
    mis = 0;
    for (int v = 0; v < 64; v++) begin
      {tx_fs_sel, tx_fs_int, tx_fs_ext, rx_fs_sel, rx_fs_int, rx_fs_ext} = 6'(v);
      #0.2;
      if (tx_fs != (v[5] ? v[3] : v[4])) mis++;
      if (rx_fs != (v[2] ? v[0] : v[1])) mis++;
    end
    chk(mis == 0, "R6 frame sync selection", mis, 0);

    // R8: mid-stream ratio change on tx with running strobe-free internal clock
    @(posedge clk); #2; tx_mode = 0; tx_hdiv = 0; tx_bdiv = 7;
    repeat (13) @(posedge clk);
    #2; tx_bdiv = 2;
    period_run(0, 3, 1'b1, "R8 restart period");

    done = 1;
    summary();
  end
endmodule